// File: doc/BRIEF.md
# DMA Channel Status and Index Registers

This block is the register slice for one direction of a bus-master DMA channel that walks a ring of buffer descriptors for an audio or modem stream. It keeps the index of the last descriptor that software has made valid. It also keeps a small status word of sticky flags that the data path raises and software clears by writing ones. Software reaches both through one 32-bit dword window with byte enables. Byte lane 1 holds the 8-bit index register, and lanes 2–3 hold the 16-bit status register. Lane 0 belongs to a neighbouring register, so it reads as zero here and ignores writes.

The data path reports several events: an overrun or underrun attempt, the end of a buffer together with that buffer's interrupt-on-completion bit, the last-valid-buffer and index-updated events, and a halted indication. The block turns them into flags, a gated interrupt, and per-direction FIFO controls. In the input (capture) direction an overrun raises `fifo_wr_inhibit`, so the sample is dropped and the FIFO pointers hold. In the output (playback) direction an underrun raises `repeat_last`, so the link resends the last good sample. The FIFO error flag is held by a two-state fault machine. Its states are FLT_CLEAR and FLT_LATCHED. The transition RAISE (CLEAR to LATCHED) fires on an xrun while more valid buffers remain. The transition ACK (LATCHED to CLEAR) fires on a software write-one to the flag when no RAISE happens in the same cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, a full-dword read returns 32'h0001_0000: the index byte (lane 1) is 00h, the status word (lanes 2–3) is 0001h, and `irq` is 0.
- R2: A write with `acc_be[1]` set loads `acc_wdata[12:8]` into the 5-bit index. Read data bits 15:13 are always 0.
- R3: Status bits 15:5 (read data bits 31:21) always read 0. Status bit 0 (read data bit 16) is read-only and shows the value `dma_halted` had at the previous clock edge.
- R4: Status bit 4 (FIFO error, read data bit 20) sets one cycle after `xrun_evt` is high together with `more_bufs`. An xrun with `more_bufs` low leaves it unchanged.
- R5: Status bit 3 (buffer completion, read data bit 19) sets one cycle after `buf_done` is high with `desc_ioc` high. `buf_done` with `desc_ioc` low leaves it unchanged.
- R6: Status bits 4:1 clear when a write with `acc_be[2]` set carries a 1 in their position. Writing 0, or writing without `acc_be[2]`, leaves them unchanged.
- R7: When a set event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Status bit 1 sets on `last_buf_evt` and status bit 2 sets on `idx_upd_evt`. Both follow the clear rule of R6.
- R9: `irq` is high exactly when (bit 3 and `ie_bc`) or (bit 4 and `ie_fe`).
- R10: With `DIR_IN`=1, `fifo_wr_inhibit` equals `xrun_evt` in the same cycle and `repeat_last` stays 0.
- R11: With `DIR_IN`=0, `repeat_last` equals `xrun_evt` in the same cycle and `fifo_wr_inhibit` stays 0.
- R12: Read data is combinational. It returns only the lanes enabled in `acc_be`, with other lanes zero, and it is all zero when no read is active. Lane 0 reads 0, and writes to lane 0 or lane 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access strobe for this dword |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_be | input | 4 | Byte-lane enables |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| dma_halted | input | 1 | Channel halted indication |
| last_buf_evt | input | 1 | Last valid buffer reached |
| idx_upd_evt | input | 1 | Current index advanced |
| buf_done | input | 1 | Final sample of current buffer processed |
| desc_ioc | input | 1 | Interrupt-on-completion bit of current descriptor |
| xrun_evt | input | 1 | Overrun (input dir) or underrun (output dir) attempt |
| more_bufs | input | 1 | Further valid buffers are pending |
| ie_bc | input | 1 | Completion interrupt enable |
| ie_fe | input | 1 | FIFO error interrupt enable |
| irq | output | 1 | Channel interrupt |
| fifo_wr_inhibit | output | 1 | Drop incoming sample, hold FIFO pointers |
| repeat_last | output | 1 | Resend last valid sample to link |

## Verification
The bench aims at same-cycle collisions of a set event and a write-one clear. A design that gave the clear priority would lose an event and read the flag back as 0. It drives xruns with no pending buffers and completions without the IOC bit, where a careless design would set flags spuriously. It writes zeros, writes with lane 2 disabled, and writes to lanes 0 and 3, which a loose byte-enable decode would let corrupt the status or index. Both directions are instantiated, so swapped inhibit and repeat outputs show up as mismatches on every xrun.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
    // status bit positions (software decodes these)
    localparam int SR_HALT = 0;
    localparam int SR_LAST = 1;
    localparam int SR_IUPD = 2;
    localparam int SR_BC   = 3;
    localparam int SR_FE   = 4;
    localparam int SR_USED = 5;
    localparam int SR_W    = 16;

    // byte lanes of the dword window
    localparam int LANE_IDX = 1;
    localparam int LANE_SR  = 2;

    typedef enum logic {
        FLT_CLEAR   = 1'b0,
        FLT_LATCHED = 1'b1
    } flt_state_t;
endpackage

// File: rtl/dmar_w1c_bit.sv
module dmar_w1c_bit #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= RST_VAL;
        else if (set_i) q <= 1'b1;   // event beats clear
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/dmar_lvi_reg.sv
module dmar_lvi_reg #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       rd_byte
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     idx_q <= '0;
        else if (wr_en) idx_q <= wr_idx;
    end

    assign rd_byte = {{(8-IDX_W){1'b0}}, idx_q};
endmodule

// File: rtl/dmar_fault_fsm.sv
module dmar_fault_fsm
    import dmar_pkg::*;
#(
    parameter bit DIR_IN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xrun_evt,
    input  logic more_bufs,
    input  logic ack_i,
    output logic flag_o,
    output logic inhibit_o,
    output logic repeat_o
);
    flt_state_t state_q, state_d;
    logic raise;

    assign raise = xrun_evt && more_bufs;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_CLEAR:   if (raise)          state_d = FLT_LATCHED;  // RAISE
            FLT_LATCHED: if (ack_i && !raise) state_d = FLT_CLEAR;   // ACK
            default:                          state_d = FLT_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o    = (state_q == FLT_LATCHED);
        inhibit_o = DIR_IN && xrun_evt;
        repeat_o  = !DIR_IN && xrun_evt;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmar_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter bit DIR_IN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [3:0]  acc_be,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    input  logic        dma_halted,
    input  logic        last_buf_evt,
    input  logic        idx_upd_evt,
    input  logic        buf_done,
    input  logic        desc_ioc,
    input  logic        xrun_evt,
    input  logic        more_bufs,
    input  logic        ie_bc,
    input  logic        ie_fe,
    output logic        irq,
    output logic        fifo_wr_inhibit,
    output logic        repeat_last
);
    localparam int IDX_LSB = 8 * LANE_IDX;
    localparam int SR_LSB  = 8 * LANE_SR;
    localparam int N_EVT   = SR_FE - SR_LAST;   // bits 1..3

    logic              wr_any, rd_any, wr_idx_ln, wr_sr_ln;
    logic [7:0]        idx_byte;
    logic              hch_q;
    logic [SR_FE-1:1]  evt_set;
    logic [SR_FE-1:1]  flag_q;
    logic              fe_flag, bc_flag;
    logic [SR_W-1:0]   sr_word;
    logic [31:0]       dword, lane_mask;
    logic              unused_wdata;

    assign wr_any    = acc_en && acc_wr;
    assign rd_any    = acc_en && !acc_wr;
    assign wr_idx_ln = wr_any && acc_be[LANE_IDX];
    assign wr_sr_ln  = wr_any && acc_be[LANE_SR];

    dmar_lvi_reg #(.IDX_W(IDX_W)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_idx_ln),
        .wr_idx  (acc_wdata[IDX_LSB +: IDX_W]),
        .rd_byte (idx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hch_q <= 1'b1;
        else        hch_q <= dma_halted;
    end

    assign evt_set[SR_LAST] = last_buf_evt;
    assign evt_set[SR_IUPD] = idx_upd_evt;
    assign evt_set[SR_BC]   = buf_done && desc_ioc;

    for (genvar b = SR_LAST; b < SR_LAST + N_EVT; b++) begin : g_flag
        dmar_w1c_bit #(.RST_VAL(1'b0)) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_set[b]),
            .clr_i (wr_sr_ln && acc_wdata[SR_LSB + b]),
            .q     (flag_q[b])
        );
    end

    dmar_fault_fsm #(.DIR_IN(DIR_IN)) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .xrun_evt  (xrun_evt),
        .more_bufs (more_bufs),
        .ack_i     (wr_sr_ln && acc_wdata[SR_LSB + SR_FE]),
        .flag_o    (fe_flag),
        .inhibit_o (fifo_wr_inhibit),
        .repeat_o  (repeat_last)
    );

    assign bc_flag = flag_q[SR_BC];
    assign sr_word = {{(SR_W-SR_USED){1'b0}}, fe_flag, flag_q, hch_q};
    assign dword   = {sr_word, idx_byte, 8'h00};

    for (genvar l = 0; l < 4; l++) begin : g_lane
        assign lane_mask[8*l +: 8] = {8{acc_be[l]}};
    end

    assign acc_rdata = rd_any ? (dword & lane_mask) : 32'h0;
    assign irq       = (bc_flag && ie_bc) || (fe_flag && ie_fe);

    assign unused_wdata = ^{acc_wdata[IDX_LSB-1:0], acc_wdata[31:SR_LSB+SR_USED],
                            acc_wdata[SR_LSB], acc_wdata[SR_LSB-1:IDX_LSB+IDX_W]};
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [3:0]  acc_be,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        dma_halted,
    input logic        buf_done,
    input logic        desc_ioc,
    input logic        xrun_evt,
    input logic        more_bufs,
    input logic        ie_bc,
    input logic        ie_fe,
    input logic        irq,
    input logic        fifo_wr_inhibit,
    input logic        repeat_last,
    input logic        fe_flag,
    input logic        bc_flag,
    input logic        hch_q
);
    // R4
    fe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xrun_evt && more_bufs |=> fe_flag);
    // R4
    fe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_flag) |-> $past(xrun_evt && more_bufs));
    // R5
    bc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done && desc_ioc |=> bc_flag);
    // R5
    bc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bc_flag) |-> $past(buf_done && desc_ioc));
    // R6
    fe_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && acc_wr && acc_be[2] && acc_wdata[20] && !(xrun_evt && more_bufs)
        |=> !fe_flag);
    // R3
    hch_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_halted |=> hch_q);
    // R3
    hch_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_halted |=> !hch_q);
    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[31:21] == 11'h0);
    // R2
    idx_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[15:13] == 3'h0);
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_bc && !ie_fe |-> !irq);
    // R10
    xrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xrun_evt |-> !fifo_wr_inhibit && !repeat_last);
    // R11
    xrun_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xrun_evt |-> fifo_wr_inhibit != repeat_last);
    // R12
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |-> acc_rdata == 32'h0);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_en          (acc_en),
    .acc_wr          (acc_wr),
    .acc_be          (acc_be),
    .acc_wdata       (acc_wdata),
    .acc_rdata       (acc_rdata),
    .dma_halted      (dma_halted),
    .buf_done        (buf_done),
    .desc_ioc        (desc_ioc),
    .xrun_evt        (xrun_evt),
    .more_bufs       (more_bufs),
    .ie_bc           (ie_bc),
    .ie_fe           (ie_fe),
    .irq             (irq),
    .fifo_wr_inhibit (fifo_wr_inhibit),
    .repeat_last     (repeat_last),
    .fe_flag         (fe_flag),
    .bc_flag         (bc_flag),
    .hch_q           (hch_q)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en, acc_wr;
    logic [3:0]  acc_be;
    logic [31:0] acc_wdata;
    logic        dma_halted, last_buf_evt, idx_upd_evt, buf_done, desc_ioc;
    logic        xrun_evt, more_bufs, ie_bc, ie_fe;
    logic [31:0] rdata_i, rdata_o;
    logic        irq_i, inh_i, rep_i, irq_o, inh_o, rep_o;

    int checks = 0;
    int errors = 0;

    // expected state
    logic [4:0] m_idx;
    logic       m_hch, m_lv, m_iu, m_bc, m_fe;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs #(.DIR_IN(1'b1)) i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .acc_rdata(rdata_i), .dma_halted(dma_halted),
        .last_buf_evt(last_buf_evt), .idx_upd_evt(idx_upd_evt), .buf_done(buf_done),
        .desc_ioc(desc_ioc), .xrun_evt(xrun_evt), .more_bufs(more_bufs),
        .ie_bc(ie_bc), .ie_fe(ie_fe), .irq(irq_i), .fifo_wr_inhibit(inh_i),
        .repeat_last(rep_i));

    dma_chan_regs #(.DIR_IN(1'b0)) i_dma_chan_regs_out (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .acc_rdata(rdata_o), .dma_halted(dma_halted),
        .last_buf_evt(last_buf_evt), .idx_upd_evt(idx_upd_evt), .buf_done(buf_done),
        .desc_ioc(desc_ioc), .xrun_evt(xrun_evt), .more_bufs(more_bufs),
        .ie_bc(ie_bc), .ie_fe(ie_fe), .irq(irq_o), .fifo_wr_inhibit(inh_o),
        .repeat_last(rep_o));

    function automatic logic [31:0] exp_dword();
        return {11'h0, m_fe, m_bc, m_iu, m_lv, m_hch, 3'h0, m_idx, 8'h00};
    endfunction

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic next_w1c(input logic q, input logic set, input logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : q);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        acc_en = 0; acc_wr = 0; acc_be = 4'h0; acc_wdata = 32'h0;
        last_buf_evt = 0; idx_upd_evt = 0; buf_done = 0; desc_ioc = 0;
        xrun_evt = 0; more_bufs = 0;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        acc_en = 1; acc_wr = 1; acc_be = be; acc_wdata = d;
    endtask

    task automatic rd(input logic [3:0] be);
        acc_en = 1; acc_wr = 0; acc_be = be; acc_wdata = 32'h0;
    endtask

    // inputs are already driven; check, then advance one clock
    task automatic step(input string tag);
        logic        w2;
        logic [31:0] exp_rd;
        #1;
        exp_rd = (acc_en && !acc_wr) ? (exp_dword() & be_mask(acc_be)) : 32'h0;
        chk(tag, rdata_i, exp_rd);
        chk("R12 out-dir read", rdata_o, exp_rd);
        chk("R9 irq", {31'h0, irq_i}, {31'h0, (m_bc & ie_bc) | (m_fe & ie_fe)});
        chk("R10 inhibit", {30'h0, inh_i, rep_i}, {30'h0, xrun_evt, 1'b0});
        chk("R11 repeat",  {30'h0, rep_o, inh_o}, {30'h0, xrun_evt, 1'b0});
        w2 = acc_en && acc_wr && acc_be[2];
        @(posedge clk);
        if (acc_en && acc_wr && acc_be[1]) m_idx = acc_wdata[12:8];
        m_hch = dma_halted;
        m_lv  = next_w1c(m_lv, last_buf_evt,        w2 && acc_wdata[17]);
        m_iu  = next_w1c(m_iu, idx_upd_evt,         w2 && acc_wdata[18]);
        m_bc  = next_w1c(m_bc, buf_done && desc_ioc, w2 && acc_wdata[19]);
        m_fe  = next_w1c(m_fe, xrun_evt && more_bufs, w2 && acc_wdata[20]);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle(); dma_halted = 0; ie_bc = 1; ie_fe = 1;
        m_idx = 0; m_hch = 1; m_lv = 0; m_iu = 0; m_bc = 0; m_fe = 0;
        repeat (3) @(negedge clk);

        // R1: reset values, read during reset
        rd(4'hF); #1;
        chk("R1 reset read", rdata_i, 32'h0001_0000);
        chk("R1 reset irq", {31'h0, irq_i}, 32'h0);
        rst_n = 1;
        dma_halted = 1;
        step("R1");

        // R2: index write via lane 1, upper bits read zero
        idle(); wr(4'b0010, 32'h0000_FF00); step("R2 write");
        idle(); rd(4'b0010); #1;
        chk("R2 idx literal", rdata_i, 32'h0000_1F00);
        step("R2 read");

        // R12: lanes 0 and 3 writes change nothing
        idle(); wr(4'b1001, 32'hFFFF_00FF); step("R12 write");
        idle(); rd(4'hF); step("R12 read");
        idle(); rd(4'b0001); #1;
        chk("R12 lane0 zero", rdata_i, 32'h0);
        step("R12 lane0");

        // R3: halted mirror
        idle(); dma_halted = 0; step("R3 drive");
        idle(); rd(4'b0100); #1;
        chk("R3 halt clear", rdata_i, 32'h0);
        step("R3 read");

        // R4: xrun without pending buffers vs with
        idle(); xrun_evt = 1; more_bufs = 0; step("R4 no more");
        idle(); rd(4'b0100); step("R4 read0");
        idle(); xrun_evt = 1; more_bufs = 1; step("R4 more");
        idle(); rd(4'b0100); #1;
        chk("R4 fe literal", rdata_i, 32'h0010_0000);
        step("R4 read1");

        // R6: zero write, missing enable, proper clear
        idle(); wr(4'b0100, 32'h0); step("R6 zero");
        idle(); wr(4'b0010, 32'h0010_0000 | {19'h0, m_idx, 8'h0}); step("R6 no lane");
        idle(); rd(4'b0100); step("R6 still set");
        idle(); wr(4'b0100, 32'h0010_0000); step("R6 clear");
        idle(); rd(4'b0100); step("R6 cleared");

        // R5: completion with and without IOC
        idle(); buf_done = 1; desc_ioc = 0; step("R5 no ioc");
        idle(); rd(4'b0100); step("R5 read0");
        idle(); buf_done = 1; desc_ioc = 1; step("R5 ioc");
        idle(); rd(4'b0100); step("R5 read1");

        // R7: set and clear in the same cycle
        idle(); wr(4'b0100, 32'h0018_0000); buf_done = 1; desc_ioc = 1;
        xrun_evt = 1; more_bufs = 1; step("R7 collide");
        idle(); rd(4'b0100); #1;
        chk("R7 both held", rdata_i, 32'h0018_0000);
        step("R7 read");

        // R9: enables gate irq
        idle(); ie_bc = 0; ie_fe = 0; step("R9 off");
        idle(); ie_bc = 1; step("R9 bc");
        idle(); ie_bc = 0; ie_fe = 1; step("R9 fe");

        // R8: last-buffer and index-updated flags
        idle(); wr(4'b0100, 32'h001E_0000); step("R8 clr all");
        idle(); last_buf_evt = 1; step("R8 lv");
        idle(); idx_upd_evt = 1; step("R8 iu");
        idle(); rd(4'b0100); #1;
        chk("R8 both set", rdata_i, 32'h0006_0000);
        step("R8 read");
        idle(); wr(4'b0100, 32'h0002_0000); step("R8 clr lv");
        idle(); rd(4'b0100); step("R8 read2");

        // random traffic
        for (int n = 0; n < N_RAND; n++) begin
            idle();
            acc_en       = ($urandom % 2) == 0;
            acc_wr       = ($urandom % 3) == 0;
            acc_be       = 4'($urandom);
            acc_wdata    = $urandom;
            dma_halted   = ($urandom % 4) == 0;
            last_buf_evt = ($urandom % 8) == 0;
            idx_upd_evt  = ($urandom % 8) == 0;
            buf_done     = ($urandom % 6) == 0;
            desc_ioc     = ($urandom % 2) == 0;
            xrun_evt     = ($urandom % 8) == 0;
            more_bufs    = ($urandom % 2) == 0;
            ie_bc        = ($urandom % 4) != 0;
            ie_fe        = ($urandom % 4) != 0;
            step("R12 random read");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule